// File: doc/BRIEF.md
# Dual Countdown Timer and Interrupt Controller

This block is a byte-wide, register-mapped peripheral that holds two 16-bit countdown timers, an interrupt flag register and an interrupt enable register, and combines them into one interrupt output. A simple strobe bus reads and writes sixteen byte registers. The register index comes from a fixed field inside a wider address. Both timers decrement once for each cycle in which an external prescaler raises `tick`.

Timer 1 always runs from its latch down through zero to 0xFFFF and then reloads. It can raise its flag on every wrap, giving a periodic interrupt. Timer 2 counts down without reloading and flags only its first zero crossing after each load.

The port, direction, shift-data and peripheral-control registers are plain storage. An external shift engine reports its events through `shift_evt`, which sets the three shift flags. Reads of some registers clear flags as a side effect. The enable register is written with set/clear semantics.

Top module: `dual_timer_irqc`

## Requirements
- R1: After reset, the index-2 direction register reads 0xFF, both Timer 1 latch bytes and both Timer 1 counter bytes read 0xFF, the enable register reads 0x80, `irq` is 0, and every other register reads 0x00 (including the Timer 2 counter).
- R2: The register index is `addr[12:9]`, and the other address bits are ignored. Indices 0, 1, 2, 3, 10, 11, 12 and 15 are plain 8-bit storage that reads back the last value written.
- R3: A write to index 14 with bit 7 = 1 ORs data bits 6:0 into the enable mask. With bit 7 = 0 it clears every mask bit whose data bit is 1. A read of index 14 returns {1, mask[6:0]}.
- R4: A write to index 13 clears each flag whose data bit is 1. A read of index 13 returns {any (flag AND mask), flags[6:0]}.
- R5: `irq` is 1 exactly when (flags AND mask AND 0x64) is nonzero. The sources are Timer 1 (bit 6), Timer 2 (bit 5) and shift-complete (bit 2).
- R6: A write to index 5 sets the Timer 1 latch high byte, loads the whole new latch into the counter and clears flag bit 6. Writes to index 4 or 6 change only the latch low byte. Index 4 and 5 reads return the live counter bytes, and index 6 and 7 reads return the latch bytes.
- R7: A write to index 7 sets the Timer 1 latch high byte and clears flag bit 6. It does not reload the counter.
- R8: Timer 1 counts latch, ..., 0, 0xFFFF, and then reloads the latch, giving a period of latch+2 ticks. With `ACR[7:6]` (index 11) = 01, flag bit 6 sets on each 0 to 0xFFFF step. The first flag comes latch+1 ticks after a load.
- R9: With `ACR[7:6]` other than 01, Timer 1 counts in the same way but never sets flag bit 6.
- R10: A write to index 9 sets the Timer 2 latch high byte (the low byte comes from index 8), loads the latch into the counter, clears flag bit 5 and arms the timer. The counter wraps from 0 to 0xFFFF without reloading. Flag bit 5 sets only on the first such crossing after a load.
- R11: Reading index 4 clears flag bit 6. Reading index 8 clears flag bit 5. Reading index 10 clears flag bits 4:2. Reading index 5 or 9 clears nothing.
- R12: `shift_evt[0]`, `shift_evt[1]` and `shift_evt[2]` set flag bits 2, 3 and 4. A flag set and a clear of the same flag in one cycle leave the flag set.
- R13: Counters change only on a `tick` cycle or on a load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Prescaler enable; each high cycle decrements both timers |
| sel | input | 1 | Bus access strobe |
| wr | input | 1 | 1 = write, 0 = read (valid with sel) |
| addr | input | 13 | Bus address; bits 12:9 pick the register |
| wdata | input | 8 | Write data |
| shift_evt | input | 3 | Shift engine events that set flag bits 4:2 |
| rdata | output | 8 | Read data for the addressed register (combinational) |
| irq | output | 1 | Interrupt request |

## Verification
The bound checker watches these properties on every cycle:
- the enable register's read-back bit 7;
- the clear-all write;
- the counter load from index 5 and the flag clears from index 5 and 7;
- the reload from 0xFFFF;
- counter stability without `tick`;
- flag silence outside free-running mode;
- the shift-flag clear on a read.

Only the bench scenarios can show the counted periods of latch+1 and latch+2 ticks for several latch values, and the one-shot behaviour of Timer 2 over a full 65536-tick wrap. The same is true of read-back of stored bytes, and of the full sweep of all 128 enable masks against a set of pending flags.

// File: rtl/dtirq_pkg.sv
package dtirq_pkg;
  localparam int CNT_W   = 16;
  localparam int BYTE_W  = 8;
  localparam int NFLAG   = 7;
  localparam int NREG    = 16;

  typedef logic [CNT_W-1:0] cnt_t;
  typedef logic [NFLAG-1:0] flag_t;

  typedef enum logic [3:0] {
    IX_PB      = 4'd0,
    IX_PA      = 4'd1,
    IX_DIRB    = 4'd2,
    IX_DIRA    = 4'd3,
    IX_T1C_LO  = 4'd4,
    IX_T1C_HI  = 4'd5,
    IX_T1L_LO  = 4'd6,
    IX_T1L_HI  = 4'd7,
    IX_T2C_LO  = 4'd8,
    IX_T2C_HI  = 4'd9,
    IX_SHIFT   = 4'd10,
    IX_AUX     = 4'd11,
    IX_PERIPH  = 4'd12,
    IX_FLAGS   = 4'd13,
    IX_ENABLE  = 4'd14,
    IX_PA_NH   = 4'd15
  } reg_idx_e;

  localparam int FB_SHIFT = 2;
  localparam int FB_T2    = 5;
  localparam int FB_T1    = 6;

  localparam flag_t IRQ_SRC_MASK = 7'h64;
  localparam flag_t SHIFT_FLAGS  = 7'h1C;

  // Timer 1 step: after 0xFFFF the latch is reloaded, else decrement.
  function automatic cnt_t reload_step(input cnt_t cnt, input cnt_t lat);
    return (cnt == '1) ? lat : cnt - cnt_t'(1);
  endfunction

  // Timer 2 step: plain modulo decrement.
  function automatic cnt_t wrap_step(input cnt_t cnt);
    return cnt - cnt_t'(1);
  endfunction

  // Enable register update: bit 7 selects set or clear of bits 6:0.
  function automatic flag_t mask_update(input flag_t cur, input logic [BYTE_W-1:0] d);
    return d[BYTE_W-1] ? (cur | d[NFLAG-1:0]) : (cur & ~d[NFLAG-1:0]);
  endfunction

  function automatic logic [BYTE_W-1:0] flag_view(input flag_t f, input flag_t m);
    return {|(f & m), f};
  endfunction
endpackage

// File: rtl/dtirq_regdec.sv
module dtirq_regdec #(
  parameter int ADDR_W  = 13,
  parameter int IDX_LSB = 9,
  parameter int NREG    = 16
) (
  input  logic                    sel,
  input  logic                    wr,
  input  logic [ADDR_W-1:0]       addr,
  output logic [$clog2(NREG)-1:0] idx,
  output logic [NREG-1:0]         wr_stb,
  output logic [NREG-1:0]         rd_stb
);
  localparam int IDX_W = $clog2(NREG);

  assign idx = addr[IDX_LSB +: IDX_W];

  for (genvar g = 0; g < NREG; g++) begin : g_stb
    assign wr_stb[g] = sel &  wr & (idx == IDX_W'(g));
    assign rd_stb[g] = sel & ~wr & (idx == IDX_W'(g));
  end
endmodule

// File: rtl/dtirq_timer.sv
module dtirq_timer
  import dtirq_pkg::*;
#(
  parameter bit   AUTO_RELOAD = 1'b0,
  parameter cnt_t RST_COUNT   = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              lo_we,
  input  logic              hi_we,
  input  logic              load,
  input  logic [BYTE_W-1:0] wbyte,
  output cnt_t              count,
  output cnt_t              latch,
  output logic              zero_cross
);
  localparam int HALF = CNT_W / 2;

  cnt_t latch_d;
  cnt_t count_d;
  cnt_t step_v;

  always_comb begin
    latch_d = latch;
    if (lo_we) latch_d[HALF-1:0]     = wbyte;
    if (hi_we) latch_d[CNT_W-1:HALF] = wbyte;
  end

  if (AUTO_RELOAD) begin : g_reload
    assign step_v = reload_step(count, latch);
  end else begin : g_wrap
    assign step_v = wrap_step(count);
  end

  always_comb begin
    if (load)      count_d = latch_d;
    else if (tick) count_d = step_v;
    else           count_d = count;
  end

  assign zero_cross = tick & ~load & (count == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch <= '1;
      count <= RST_COUNT;
    end else begin
      latch <= latch_d;
      count <= count_d;
    end
  end
endmodule

// File: rtl/dtirq_intc.sv
module dtirq_intc
  import dtirq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  flag_t             set_vec,
  input  flag_t             clr_vec,
  input  logic              ier_we,
  input  logic [BYTE_W-1:0] wbyte,
  output flag_t             ifr,
  output flag_t             ier,
  output logic              irq,
  output logic [BYTE_W-1:0] flags_rd,
  output logic [BYTE_W-1:0] mask_rd
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ifr <= '0;
      ier <= '0;
    end else begin
      ifr <= (ifr & ~clr_vec) | set_vec;
      if (ier_we) ier <= mask_update(ier, wbyte);
    end
  end

  assign irq      = |(ifr & ier & IRQ_SRC_MASK);
  assign flags_rd = flag_view(ifr, ier);
  assign mask_rd  = {1'b1, ier};
endmodule

// File: rtl/dual_timer_irqc.sv
module dual_timer_irqc
  import dtirq_pkg::*;
#(
  parameter int ADDR_W  = 13,
  parameter int IDX_LSB = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              sel,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  input  logic [2:0]        shift_evt,
  output logic [7:0]        rdata,
  output logic              irq
);
  localparam int HALF = CNT_W / 2;

  logic [3:0]      idx;
  logic [NREG-1:0] wr_stb;
  logic [NREG-1:0] rd_stb;

  dtirq_regdec #(.ADDR_W(ADDR_W), .IDX_LSB(IDX_LSB), .NREG(NREG)) u_dec (
    .sel(sel), .wr(wr), .addr(addr), .idx(idx), .wr_stb(wr_stb), .rd_stb(rd_stb)
  );

  // Plain storage registers
  logic [7:0] pb_q, pa_q, dirb_q, dira_q, shift_q, aux_q, periph_q, panh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pb_q     <= '0;
      pa_q     <= '0;
      dirb_q   <= 8'hFF;
      dira_q   <= '0;
      shift_q  <= '0;
      aux_q    <= '0;
      periph_q <= '0;
      panh_q   <= '0;
    end else begin
      if (wr_stb[IX_PB])     pb_q     <= wdata;
      if (wr_stb[IX_PA])     pa_q     <= wdata;
      if (wr_stb[IX_DIRB])   dirb_q   <= wdata;
      if (wr_stb[IX_DIRA])   dira_q   <= wdata;
      if (wr_stb[IX_SHIFT])  shift_q  <= wdata;
      if (wr_stb[IX_AUX])    aux_q    <= wdata;
      if (wr_stb[IX_PERIPH]) periph_q <= wdata;
      if (wr_stb[IX_PA_NH])  panh_q   <= wdata;
    end
  end

  // Timer 1: auto-reloading
  cnt_t t1_count, t1_latch;
  logic t1_load, t1_evt;
  assign t1_load = wr_stb[IX_T1C_HI];

  dtirq_timer #(.AUTO_RELOAD(1'b1), .RST_COUNT('1)) u_t1 (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .lo_we(wr_stb[IX_T1C_LO] | wr_stb[IX_T1L_LO]),
    .hi_we(wr_stb[IX_T1C_HI] | wr_stb[IX_T1L_HI]),
    .load(t1_load), .wbyte(wdata),
    .count(t1_count), .latch(t1_latch), .zero_cross(t1_evt)
  );

  // Timer 2: wrapping, one-shot flag
  cnt_t t2_count, t2_latch;
  logic t2_load, t2_evt, t2_armed;
  assign t2_load = wr_stb[IX_T2C_HI];

  dtirq_timer #(.AUTO_RELOAD(1'b0), .RST_COUNT('0)) u_t2 (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .lo_we(wr_stb[IX_T2C_LO]),
    .hi_we(wr_stb[IX_T2C_HI]),
    .load(t2_load), .wbyte(wdata),
    .count(t2_count), .latch(t2_latch), .zero_cross(t2_evt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       t2_armed <= 1'b0;
    else if (t2_load) t2_armed <= 1'b1;
    else if (t2_evt)  t2_armed <= 1'b0;
  end

  // Flag set/clear sources
  logic  t1_free;
  logic  t1_flag_set, t2_flag_set;
  flag_t set_vec, clr_vec;

  assign t1_free     = (aux_q[7:6] == 2'b01);
  assign t1_flag_set = t1_evt & t1_free;
  assign t2_flag_set = t2_evt & t2_armed;

  always_comb begin
    set_vec = '0;
    set_vec[FB_T1] = t1_flag_set;
    set_vec[FB_T2] = t2_flag_set;
    set_vec[FB_SHIFT +: 3] = shift_evt;

    clr_vec = wr_stb[IX_FLAGS] ? wdata[NFLAG-1:0] : '0;
    if (rd_stb[IX_T1C_LO] | wr_stb[IX_T1C_HI] | wr_stb[IX_T1L_HI]) clr_vec[FB_T1] = 1'b1;
    if (rd_stb[IX_T2C_LO] | wr_stb[IX_T2C_HI])                     clr_vec[FB_T2] = 1'b1;
    if (rd_stb[IX_SHIFT])                                          clr_vec = clr_vec | SHIFT_FLAGS;
  end

  flag_t      ifr_q, ier_q;
  logic [7:0] flags_rd, mask_rd;

  dtirq_intc u_intc (
    .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .clr_vec(clr_vec),
    .ier_we(wr_stb[IX_ENABLE]), .wbyte(wdata),
    .ifr(ifr_q), .ier(ier_q), .irq(irq), .flags_rd(flags_rd), .mask_rd(mask_rd)
  );

  // Read multiplexer
  always_comb begin
    unique case (reg_idx_e'(idx))
      IX_PB:     rdata = pb_q;
      IX_PA:     rdata = pa_q;
      IX_DIRB:   rdata = dirb_q;
      IX_DIRA:   rdata = dira_q;
      IX_T1C_LO: rdata = t1_count[HALF-1:0];
      IX_T1C_HI: rdata = t1_count[CNT_W-1:HALF];
      IX_T1L_LO: rdata = t1_latch[HALF-1:0];
      IX_T1L_HI: rdata = t1_latch[CNT_W-1:HALF];
      IX_T2C_LO: rdata = t2_count[HALF-1:0];
      IX_T2C_HI: rdata = t2_count[CNT_W-1:HALF];
      IX_SHIFT:  rdata = shift_q;
      IX_AUX:    rdata = aux_q;
      IX_PERIPH: rdata = periph_q;
      IX_FLAGS:  rdata = flags_rd;
      IX_ENABLE: rdata = mask_rd;
      IX_PA_NH:  rdata = panh_q;
      default:   rdata = '0;
    endcase
  end

  logic unused_ok;
  assign unused_ok = ^{t2_latch, rd_stb[IX_PB], rd_stb[IX_PA]};
endmodule

// File: rtl/dtirq_chk.sv
module dtirq_chk
  import dtirq_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       tick,
  input logic       sel,
  input logic       wr,
  input logic [3:0] idx,
  input logic [7:0] wdata,
  input logic [2:0] shift_evt,
  input logic [7:0] rdata,
  input logic       irq,
  input cnt_t       t1_count,
  input cnt_t       t1_latch,
  input logic       t1_load,
  input flag_t      ifr_q,
  input logic [7:0] aux_q
);
  AST_MASK_CLEARALL: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && wr && idx == 4'd14 && wdata == 8'h7F) |=> !irq); // R3

  AST_MASK_RD_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && !wr && idx == 4'd14) |-> rdata[7]); // R3

  AST_T1_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && wr && idx == 4'd5) |=> (t1_count == {$past(wdata), $past(t1_latch[7:0])})); // R6

  AST_T1_FLAG_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && wr && (idx == 4'd5 || idx == 4'd7) && !(tick && t1_count == '0)) |=> !ifr_q[6]); // R7

  AST_T1_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !t1_load && t1_count == '1) |=> (t1_count == $past(t1_latch))); // R8

  AST_T1_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (aux_q[7:6] != 2'b01) |=> !$rose(ifr_q[6])); // R9

  AST_T1_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !t1_load) |=> $stable(t1_count)); // R13

  AST_SHIFT_RD_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && !wr && idx == 4'd10 && shift_evt == 3'b000) |=> (ifr_q[4:2] == 3'b000)); // R11
endmodule

bind dual_timer_irqc dtirq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .sel(sel), .wr(wr), .idx(idx),
  .wdata(wdata), .shift_evt(shift_evt), .rdata(rdata), .irq(irq),
  .t1_count(t1_count), .t1_latch(t1_latch), .t1_load(t1_load),
  .ifr_q(ifr_q), .aux_q(aux_q)
);

// File: tb/sim_dual_timer_irqc.sv
module sim_dual_timer_irqc;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        sel = 1'b0;
  logic        wr = 1'b0;
  logic [12:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic [2:0]  shift_evt = '0;
  logic [7:0]  rdata;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_timer_irqc u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .sel(sel), .wr(wr), .addr(addr),
    .wdata(wdata), .shift_evt(shift_evt), .rdata(rdata), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  task automatic bus_wr(input int ix, input logic [7:0] d, input logic [8:0] junk = 9'h0);
    @(negedge clk);
    sel = 1'b1; wr = 1'b1; addr = {4'(ix), junk}; wdata = d;
    @(negedge clk);
    sel = 1'b0; wr = 1'b0;
  endtask

  task automatic bus_rd(input int ix, output logic [7:0] d, input logic [8:0] junk = 9'h0);
    @(negedge clk);
    sel = 1'b1; wr = 1'b0; addr = {4'(ix), junk};
    #1 d = rdata;
    @(negedge clk);
    sel = 1'b0;
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic pulse_shift(input logic [2:0] v);
    @(negedge clk);
    shift_evt = v;
    @(negedge clk);
    shift_evt = 3'b000;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    logic [7:0] exp_rst [16];
    int lv [3];
    lv = '{0, 3, 7};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    exp_rst = '{8'h00, 8'h00, 8'hFF, 8'h00, 8'hFF, 8'hFF, 8'hFF, 8'hFF,
                8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h80, 8'h00};
    chk("R1 irq after reset", 32'(irq), 32'h0);
    for (int i = 0; i < 16; i++) begin
      bus_rd(i, r);
      chk($sformatf("R1 reset reg %0d", i), 32'(r), 32'(exp_rst[i]));
    end

    // R2: plain storage, index from addr[12:9], other bits ignored
    for (int p = 0; p < 2; p++) begin
      for (int i = 0; i < 16; i++) begin
        if (i inside {0, 1, 2, 3, 10, 12, 15}) begin
          logic [7:0] v;
          v = 8'((i * 37 + 5) ^ (p * 8'hA5));
          bus_wr(i, v, 9'(i * 29 + 1));
          bus_rd(i, r, 9'(i * 13 + 7));
          chk($sformatf("R2 storage reg %0d", i), 32'(r), 32'(v));
        end
      end
    end
    bus_wr(11, 8'h3C);
    bus_rd(11, r);
    chk("R2 storage reg 11", 32'(r), 32'h3C);
    bus_wr(11, 8'h00);

    // R3: enable register set/clear
    bus_wr(14, 8'h7F);
    bus_wr(14, 8'h85);
    bus_rd(14, r); chk("R3 set 0x05", 32'(r), 32'h85);
    bus_wr(14, 8'hC0);
    bus_rd(14, r); chk("R3 set 0x40", 32'(r), 32'hC5);
    bus_wr(14, 8'h04);
    bus_rd(14, r); chk("R3 clear 0x04", 32'(r), 32'hC1);
    bus_wr(14, 8'h7F);
    bus_rd(14, r); chk("R3 clear all", 32'(r), 32'h80);

    // R8: free-running period for several latch values
    for (int k = 0; k < 3; k++) begin
      int lval;
      int n;
      bit f;
      lval = lv[k];
      bus_wr(11, 8'h40);
      bus_wr(4, 8'(lval));
      bus_wr(5, 8'h00);
      bus_rd(4, r); chk("R6 load low byte", 32'(r), 32'(lval));
      bus_rd(5, r); chk("R6 load high byte", 32'(r), 32'h0);
      n = 0; f = 1'b0;
      while (!f && n < 40) begin
        ticks(1); n++;
        bus_rd(13, r); f = r[6];
      end
      chk($sformatf("R8 first flag after ticks, latch %0d", lval), 32'(n), 32'(lval + 1));
      bus_rd(5, r); chk("R8 count high at wrap", 32'(r), 32'hFF);
      bus_rd(13, r); chk("R11 high read keeps T1 flag", 32'(r[6]), 32'h1);
      bus_rd(4, r); chk("R8 count low at wrap", 32'(r), 32'hFF);
      bus_rd(13, r); chk("R11 low read clears T1 flag", 32'(r[6]), 32'h0);
      n = 0; f = 1'b0;
      while (!f && n < 40) begin
        ticks(1); n++;
        bus_rd(13, r); f = r[6];
      end
      chk($sformatf("R8 period, latch %0d", lval), 32'(n), 32'(lval + 2));
      bus_wr(13, 8'h7F);
    end

    // R6/R7/R9/R13: latch byte writes and non-free-running mode
    bus_wr(11, 8'h00);
    bus_wr(4, 8'h10);
    bus_wr(5, 8'h00);
    ticks(3);
    bus_rd(4, r); chk("R13 count after 3 ticks", 32'(r), 32'h0D);
    repeat (5) @(negedge clk);
    bus_rd(4, r); chk("R13 count holds without tick", 32'(r), 32'h0D);
    bus_wr(6, 8'h21);
    bus_rd(6, r); chk("R6 latch low via index 6", 32'(r), 32'h21);
    bus_rd(4, r); chk("R6 low write leaves count", 32'(r), 32'h0D);
    bus_wr(7, 8'h12);
    bus_rd(7, r); chk("R7 latch high written", 32'(r), 32'h12);
    bus_rd(5, r); chk("R7 no reload high", 32'(r), 32'h00);
    bus_rd(4, r); chk("R7 no reload low", 32'(r), 32'h0D);
    bus_wr(5, 8'h02);
    bus_rd(4, r); chk("R6 reload low from latch", 32'(r), 32'h21);
    bus_rd(5, r); chk("R6 reload high", 32'(r), 32'h02);
    ticks(16'h0221 + 1);
    bus_rd(5, r); chk("R9 count wrapped high", 32'(r), 32'hFF);
    bus_rd(13, r); chk("R9 no T1 flag in one-shot mode", 32'(r[6]), 32'h0);
    ticks(1);
    bus_rd(5, r); chk("R9 reload high", 32'(r), 32'h02);
    bus_rd(4, r); chk("R9 reload low", 32'(r), 32'h21);
    bus_wr(11, 8'hC0);
    bus_wr(4, 8'h00);
    bus_wr(5, 8'h00);
    ticks(4);
    bus_rd(13, r); chk("R9 no T1 flag in mode 11", 32'(r[6]), 32'h0);

    // R7: latch-high write clears flag without reload
    bus_wr(11, 8'h40);
    bus_wr(4, 8'h00);
    bus_wr(5, 8'h00);
    ticks(1);
    bus_rd(13, r); chk("R8 flag at latch 0", 32'(r[6]), 32'h1);
    bus_wr(7, 8'h00);
    bus_rd(13, r); chk("R7 latch high clears T1 flag", 32'(r[6]), 32'h0);
    bus_rd(5, r); chk("R7 count not reloaded", 32'(r), 32'hFF);
    bus_wr(11, 8'h00);

    // R10: Timer 2 one-shot
    bus_wr(13, 8'h7F);
    bus_wr(8, 8'h05);
    bus_wr(9, 8'h00);
    bus_rd(9, r); chk("R10 load high", 32'(r), 32'h00);
    ticks(5);
    bus_rd(13, r); chk("R10 no flag at zero", 32'(r[5]), 32'h0);
    ticks(1);
    bus_rd(13, r); chk("R10 flag on crossing", 32'(r[5]), 32'h1);
    bus_rd(9, r); chk("R10 wrapped high", 32'(r), 32'hFF);
    bus_rd(13, r); chk("R11 T2 high read keeps flag", 32'(r[5]), 32'h1);
    bus_rd(8, r); chk("R10 wrapped low", 32'(r), 32'hFF);
    bus_rd(13, r); chk("R11 T2 low read clears flag", 32'(r[5]), 32'h0);
    ticks(65536);
    bus_rd(9, r); chk("R10 no reload after full wrap", 32'(r), 32'hFF);
    bus_rd(13, r); chk("R10 one-shot: no second flag", 32'(r[5]), 32'h0);

    // R12/R4/R11: shift flags
    bus_wr(13, 8'h7F);
    pulse_shift(3'b101);
    bus_rd(13, r); chk("R12 shift_evt sets bits 4 and 2", 32'(r), 32'h14);
    bus_rd(10, r);
    bus_rd(13, r); chk("R11 shift read clears bits 4:2", 32'(r), 32'h00);
    pulse_shift(3'b111);
    bus_wr(13, 8'h04);
    bus_rd(13, r); chk("R4 write-one clear", 32'(r), 32'h18);
    bus_wr(14, 8'h88);
    bus_rd(13, r); chk("R4 pending summary bit", 32'(r), 32'h98);
    bus_wr(14, 8'h7F);
    bus_wr(13, 8'h7F);
    @(negedge clk);
    sel = 1'b1; wr = 1'b1; addr = {4'd13, 9'h0}; wdata = 8'h08; shift_evt = 3'b010;
    @(negedge clk);
    sel = 1'b0; wr = 1'b0; shift_evt = 3'b000;
    bus_rd(13, r); chk("R12 set wins over clear", 32'(r), 32'h08);

    // R5: sweep every enable mask against flags 0x7C
    bus_wr(13, 8'h7F);
    bus_wr(11, 8'h40);
    bus_wr(4, 8'h00);
    bus_wr(5, 8'h00);
    bus_wr(8, 8'h00);
    bus_wr(9, 8'h00);
    ticks(1);
    bus_wr(11, 8'h00);
    pulse_shift(3'b111);
    bus_rd(13, r); chk("R5 flags before sweep", 32'(r[6:0]), 32'h7C);
    for (int v = 0; v < 128; v++) begin
      bus_wr(14, 8'h7F);
      bus_wr(14, 8'(8'h80 | v));
      chk($sformatf("R5 irq mask %0h", v), 32'(irq), 32'(((v & 8'h64) != 0) ? 1 : 0));
      bus_rd(13, r);
      chk($sformatf("R4 summary mask %0h", v), 32'(r[7]), 32'(((v & 8'h7C) != 0) ? 1 : 0));
      bus_rd(14, r);
      chk($sformatf("R3 mask read %0h", v), 32'(r), 32'(8'h80 | v));
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule